// File: doc/BRIEF.md
# Boundary Write Guard for a 512-Byte Memory

This block decides, byte by byte, whether a write to a 512-byte non-volatile array may be committed. The write engine presents each byte's 9-bit address and data with a one-cycle strobe. The guard answers in the same cycle with a permit flag. The array is written only when that flag is high. The serial front end, the array and the program-cycle timer are outside this block.

Protection covers only the upper 256-byte half. A control byte held at the topmost address (1FFh) defines it. Its five high bits give a lower boundary in 8-byte rows within the upper half (boundary = 100h + 8 × pointer). Bit 2 is an active-low enable flag: 0 means enabled. When the external protect pin is high and the flag is 0, every byte from the boundary up to 1FFh is refused. The top byte is in that range, so it locks itself. A second pin, present when the parameter `HAS_WC` is set, refuses every write while it is high.

The guard keeps a shadow copy of the control byte. The shadow loads from the array through a load strobe, for example after power-up. It also follows every permitted write to 1FFh. Because each byte is judged on its own address, a burst cannot run past the boundary.

Top module: `wpg_top`

## Requirements
- R1: After reset the shadow control byte reads FFh (flag bit 2 = 1, protection off), and a write to 1FFh with the protect pin high is permitted.
- R2: With the write-control pin low, a strobed write to any address with bit 8 = 0 (000h–0FFh) is always permitted, whatever the control byte and protect pin.
- R3: With the protect pin high and shadow bit 2 = 0, a strobed write to an address with bit 8 = 1 and address bits [7:3] ≥ shadow bits [7:3] is refused. This includes pointer 0, which protects all of 100h–1FFh.
- R4: Under the conditions of R3, an upper-half address whose bits [7:3] are below the pointer is permitted.
- R5: Shadow bit 2 = 1 disables protection: writes inside the pointer's range are permitted even with the protect pin high.
- R6: With the protect pin low, 1FFh is an ordinary byte. A write to it is permitted, and the shadow takes the written data on the next clock edge.
- R7: While protection is active, a write to 1FFh is refused and the shadow keeps its value.
- R8: With `HAS_WC` = 1 and the write-control pin high, every write is refused and the shadow is left unchanged.
- R9: The permit flag is low in every cycle without the write strobe.
- R10: A load strobe copies the stored-byte input into the shadow on the next edge. It takes priority over a permitted write to 1FFh in the same cycle.
- R11: Shadow bits [1:0] do not affect the decision. Only bits [7:3] and bit 2 are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrAddr | input | 9 | Target byte address of the pending write |
| wrData | input | 8 | Data byte of the pending write |
| wrStrobe | input | 1 | One-cycle request to commit a byte |
| ctrlLoad | input | 1 | Load the shadow from `ctrlIn` |
| ctrlIn | input | 8 | Control byte as read from the array |
| protPin | input | 1 | Protect enable pin, active high |
| wcPin | input | 1 | Hard write lock pin, active high (tie low if unused) |
| allowOk | output | 1 | Write may be committed this cycle |
| ctrlShadow | output | 8 | Current shadow of the control byte |

## Verification
A wrong shadow value appears at `ctrlShadow` one edge after the load or write that caused it. It also moves the protected boundary, so the permit flag gives the wrong answer for addresses near the pointer in the very next strobed cycle. The tests therefore pair each shadow update with probes just below and at the boundary, at 1FFh and in the lower half. A faulty comparison or flag polarity shows at once, because the permit flag is combinational from the address and the pins.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  // Strobes from the decision logic to the shadow register.
  typedef struct packed {
    logic takeStored;  // copy the byte read from the array
    logic takeWrite;   // follow a permitted write to the top address
  } shadowCmd_t;
endpackage

// File: rtl/wpg_shadow.sv
module wpg_shadow
  import wpg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shadowCmd_t        cmd,
  input  logic [DATA_W-1:0] ctrlIn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] shadowOut
);
  logic [DATA_W-1:0] shadowQ;

  // Erased-array value on reset: all ones, flag set, protection off.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shadowQ <= '1;
    else if (cmd.takeStored) shadowQ <= ctrlIn;
    else if (cmd.takeWrite)  shadowQ <= wrData;
  end

  assign shadowOut = shadowQ;

  // R10
  load_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cmd.takeStored)) |-> (shadowOut == $past(ctrlIn)));

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(cmd.takeStored) && !$past(cmd.takeWrite)) |-> $stable(shadowOut));
endmodule

// File: rtl/wpg_decide.sv
module wpg_decide
  import wpg_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 8,
  parameter int GRAN_BITS = 3,
  parameter int FLAG_BIT  = 2,
  parameter bit HAS_WC    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrStrobe,
  input  logic              ctrlLoad,
  input  logic              protPin,
  input  logic              wcPin,
  input  logic [DATA_W-1:0] shadow,
  output logic              allowOk,
  output shadowCmd_t        cmd
);
  localparam int ROW_W = ADDR_W - 1 - GRAN_BITS;  // row index inside a half
  localparam int PTR_W = DATA_W - GRAN_BITS;      // pointer field width

  logic             upperHalf;
  logic [ROW_W-1:0] rowIdx;
  logic [PTR_W-1:0] boundRow;
  logic             guardActive;
  logic             inWindow;
  logic             hardLock;
  logic             permit;
  logic             isTop;

  assign upperHalf   = wrAddr[ADDR_W-1];
  assign rowIdx      = wrAddr[ADDR_W-2:GRAN_BITS];
  assign boundRow    = shadow[DATA_W-1:GRAN_BITS];
  assign guardActive = protPin && !shadow[FLAG_BIT];
  assign inWindow    = upperHalf && (rowIdx >= boundRow);
  assign isTop       = (wrAddr == {ADDR_W{1'b1}});

  generate
    if (HAS_WC) begin : g_wcLock
      assign hardLock = wcPin;
    end else begin : g_noLock
      assign hardLock = 1'b0;
    end
  endgenerate

  assign permit  = !hardLock && !(guardActive && inWindow);
  assign allowOk = wrStrobe && permit;

  assign cmd.takeStored = ctrlLoad;
  assign cmd.takeWrite  = allowOk && isTop && !ctrlLoad;

  // R9
  allow_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    allowOk |-> wrStrobe);

  // R8
  wc_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_WC && wcPin) |-> (!allowOk && !cmd.takeWrite));

  // R2
  lower_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !wrAddr[ADDR_W-1] && !(HAS_WC && wcPin)) |-> allowOk);

  // R7
  top_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && isTop && protPin && !shadow[FLAG_BIT]) |-> !allowOk);
endmodule

// File: rtl/wpg_top.sv
module wpg_top
  import wpg_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 8,
  parameter int GRAN_BITS = 3,
  parameter int FLAG_BIT  = 2,
  parameter bit HAS_WC    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrStrobe,
  input  logic              ctrlLoad,
  input  logic [DATA_W-1:0] ctrlIn,
  input  logic              protPin,
  input  logic              wcPin,
  output logic              allowOk,
  output logic [DATA_W-1:0] ctrlShadow
);
  shadowCmd_t        cmd;
  logic [DATA_W-1:0] shadowVal;

  wpg_decide #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRAN_BITS(GRAN_BITS),
    .FLAG_BIT(FLAG_BIT), .HAS_WC(HAS_WC)
  ) decide_i (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrStrobe(wrStrobe),
    .ctrlLoad(ctrlLoad), .protPin(protPin), .wcPin(wcPin),
    .shadow(shadowVal), .allowOk(allowOk), .cmd(cmd)
  );

  wpg_shadow #(.DATA_W(DATA_W)) shadow_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .ctrlIn(ctrlIn),
    .wrData(wrData), .shadowOut(shadowVal)
  );

  assign ctrlShadow = shadowVal;
endmodule

// File: tb/wpg_top_tb.sv
`timescale 1ns/1ps
module wpg_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [8:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       wrStrobe = 1'b0;
  logic       ctrlLoad = 1'b0;
  logic [7:0] ctrlIn = '0;
  logic       protPin = 1'b0;
  logic       wcPin = 1'b0;
  logic       allowOk;
  logic [7:0] ctrlShadow;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  wpg_top dut_i (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData),
    .wrStrobe(wrStrobe), .ctrlLoad(ctrlLoad), .ctrlIn(ctrlIn),
    .protPin(protPin), .wcPin(wcPin), .allowOk(allowOk), .ctrlShadow(ctrlShadow)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Present one strobed write after a falling edge; sample permit mid-cycle.
  task automatic probe(input string req, input logic [8:0] a, input logic [7:0] d, input bit exp);
    @(negedge clk);
    wrAddr = a; wrData = d; wrStrobe = 1'b1; ctrlLoad = 1'b0;
    #2 check(req, allowOk, exp);
  endtask

  task automatic idle();
    @(negedge clk);
    wrStrobe = 1'b0; ctrlLoad = 1'b0;
  endtask

  task automatic loadCtrl(input logic [7:0] v);
    @(negedge clk);
    wrStrobe = 1'b0; ctrlLoad = 1'b1; ctrlIn = v;
    @(negedge clk);
    ctrlLoad = 1'b0;
    check("R10", ctrlShadow, v);
  endtask

  task automatic testReset();
    check("R1", ctrlShadow, 8'hFF);
    protPin = 1'b1;
    probe("R1", 9'h1FF, 8'h55, 1'b1);
    @(negedge clk);
    wrStrobe = 1'b0; wrAddr = 9'h000;
    #2 check("R9", allowOk, 0);
  endtask

  task automatic testOpenTop();
    protPin = 1'b0;
    probe("R6", 9'h1FF, 8'hA0, 1'b1);
    idle();
    check("R6", ctrlShadow, 8'hA0);
  endtask

  task automatic testWindow();
    protPin = 1'b1;
    probe("R3", 9'h1A0, 8'h11, 1'b0);
    probe("R3", 9'h1C5, 8'h11, 1'b0);
    probe("R7", 9'h1FF, 8'h00, 1'b0);
    idle();
    check("R7", ctrlShadow, 8'hA0);
    probe("R4", 9'h19F, 8'h11, 1'b1);
    probe("R4", 9'h100, 8'h11, 1'b1);
    probe("R2", 9'h0FF, 8'h11, 1'b1);
    probe("R2", 9'h000, 8'h11, 1'b1);
    idle();
  endtask

  task automatic testLowBits();
    loadCtrl(8'hA3);
    protPin = 1'b1;
    probe("R11", 9'h1A0, 8'h00, 1'b0);
    probe("R11", 9'h19F, 8'h00, 1'b1);
    idle();
  endtask

  task automatic testFlagOff();
    loadCtrl(8'hA4);
    protPin = 1'b1;
    probe("R5", 9'h1FF, 8'hA4, 1'b1);
    probe("R5", 9'h1B0, 8'h00, 1'b1);
    idle();
  endtask

  task automatic testPointerZero();
    loadCtrl(8'h00);
    protPin = 1'b1;
    probe("R3", 9'h100, 8'h00, 1'b0);
    probe("R2", 9'h0F8, 8'h00, 1'b1);
    idle();
  endtask

  task automatic testHardLock();
    loadCtrl(8'hA0);
    protPin = 1'b0; wcPin = 1'b1;
    probe("R8", 9'h000, 8'h00, 1'b0);
    probe("R8", 9'h1FF, 8'h3C, 1'b0);
    idle();
    check("R8", ctrlShadow, 8'hA0);
    wcPin = 1'b0;
  endtask

  task automatic testLoadPriority();
    protPin = 1'b0;
    @(negedge clk);
    wrAddr = 9'h1FF; wrData = 8'h00; wrStrobe = 1'b1;
    ctrlLoad = 1'b1; ctrlIn = 8'hFF;
    @(negedge clk);
    wrStrobe = 1'b0; ctrlLoad = 1'b0;
    check("R10", ctrlShadow, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testOpenTop();
    testWindow();
    testLowBits();
    testFlagOff();
    testPointerZero();
    testHardLock();
    testLoadPriority();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule